// File: doc/BRIEF.md
# Accumulator Arithmetic Execute Unit

This block runs the 8-bit add, add-with-carry and subtract operations of a small 8-bit processor core. It holds the accumulator A, the six general registers B, C, D, E, H and L, and a four-flag register: zero (Z), subtract (N), half-carry (H) and carry (C). An opcode byte is accepted through a valid/ready handshake. For the two-byte immediate forms, the operand byte is accepted together with the opcode. The result goes back to A, all four flags are rewritten, and `done` is high for one cycle when the instruction retires.

The low three opcode bits select the source operand. One of the eight slots is a byte in memory, addressed by the H:L register pair. For that slot the block spends one extra cycle driving a read request, and it uses the returned byte in the following cycle. Preload port `ld_*` gives the surrounding core (and the testbench) write access to the registers and the flags.

Top module: `acc_alu_unit`

## Requirements
- R1: After a synchronous active-high reset, A, B, C, D, E, H, L and the flags are all zero, `in_ready` is 1, and `done` and `mem_rd_en` are 0.
- R2: An opcode is taken on a clock edge where `in_valid` and `in_ready` are both high. For register and immediate forms, `done` is high for exactly the one cycle after acceptance, and the new A and flags are visible the cycle after that. `in_ready` stays low from acceptance until `done` falls.
- R3: For opcodes 0x80 to 0x97, bits [2:0] select the source: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte at {H,L}, 7=A.
- R4: Opcodes 0x80 to 0x87, and 0xC6 with its immediate byte, set A to A+source modulo 256. The carry flag is ignored. N is cleared.
- R5: Opcodes 0x88 to 0x8F, and 0xCE with its immediate byte, set A to A+source+C modulo 256. The incoming carry counts toward both the half-carry and the carry out.
- R6: Opcodes 0x90 to 0x97 set A to A-source modulo 256 and set N. H is set on a borrow into bit 4 and C is set on a borrow out of bit 7.
- R7: For additions, H is the carry out of bit 3 and C the carry out of bit 7. For every operation, Z is 1 exactly when the 8-bit result is 0. Each executed instruction rewrites all four flags, whatever their previous values.
- R8: `flags_out` places Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Bits 3:0 are always 0.
- R9: For memory-source forms (low bits 6), the cycle after acceptance has `mem_rd_en`=1 and `mem_rd_addr`={H,L}. `mem_rd_data` is used in the next cycle, which is also the `done` cycle.
- R10: Any other opcode (for example 0x00, 0xA7, 0xC7) gets a `done` pulse one cycle after acceptance and leaves A and the flags unchanged.
- R11: `ld_en` writes `ld_data` at the next edge into the register selected by `ld_sel`, using the R3 encoding for 0 to 5 and 7. `ld_sel`=6 loads the flags from `ld_data[7:4]`. An executing instruction's write to A or the flags wins over a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Opcode (and immediate) present |
| in_ready | output | 1 | Block idle and able to take an opcode |
| in_opcode | input | 8 | Opcode byte |
| in_imm | input | 8 | Immediate byte for 0xC6 / 0xCE |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Read address {H,L} |
| mem_rd_data | input | 8 | Read data, used the cycle after the request |
| ld_en | input | 1 | Register preload strobe |
| ld_sel | input | 3 | Preload target (6 selects the flags) |
| ld_data | input | 8 | Preload value |
| acc_out | output | 8 | Current value of A |
| flags_out | output | 8 | Flag byte {Z,N,H,C,0000} |
| done | output | 1 | Instruction retired |

## Verification
Some properties hold every cycle, and the bound assertions check those:
- `done` stays a single-cycle pulse and never overlaps `in_ready`.
- Every memory request carries the current H:L address and is followed directly by `done`.
- N tracks the operation class, and Z agrees with the written accumulator.
- The low nibble of the flag byte stays zero, and a rejected opcode leaves A and the flags untouched.

The exact sum, the half-carry and borrow positions, the carry-in effect of the add-with-carry forms, and the source chosen by each opcode are data-dependent. Only the bench's vector table shows those, along with the directed reset and unsupported-opcode cases.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DW      = 8;
    localparam int AW      = 2 * DW;
    localparam int SEL_W   = 3;
    localparam int NREG    = 1 << SEL_W;
    localparam int NIB     = 4;
    localparam int FLAG_W  = 4;
    localparam int SRC_H   = 4;
    localparam int SRC_L   = 5;
    localparam int SRC_MEM = 6;
    localparam int SRC_A   = 7;
    localparam logic [DW-1:0] OPC_IMM_ADD = 8'hC6;
    localparam logic [DW-1:0] OPC_IMM_ADC = 8'hCE;

    typedef enum logic [1:0] {OP_NONE, OP_ADD, OP_ADC, OP_SUB} op_kind_t;
    typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_EXEC} state_t;

    typedef struct packed {
        op_kind_t           kind;
        logic [SEL_W-1:0]   src;
        logic               use_imm;
        logic               use_mem;
    } dec_t;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    function automatic dec_t decode_op(input logic [DW-1:0] opc);
        dec_t d;
        d.kind    = OP_NONE;
        d.src     = opc[SEL_W-1:0];
        d.use_imm = 1'b0;
        case (opc[DW-1:SEL_W])
            5'b10000: d.kind = OP_ADD;
            5'b10001: d.kind = OP_ADC;
            5'b10010: d.kind = OP_SUB;
            default:  d.kind = OP_NONE;
        endcase
        if (opc == OPC_IMM_ADD) begin
            d.kind    = OP_ADD;
            d.use_imm = 1'b1;
        end
        if (opc == OPC_IMM_ADC) begin
            d.kind    = OP_ADC;
            d.use_imm = 1'b1;
        end
        d.use_mem = (d.kind != OP_NONE) && !d.use_imm
                    && (opc[SEL_W-1:0] == SEL_W'(SRC_MEM));
        return d;
    endfunction
endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_pkg::*;
(
    input  op_kind_t         kind,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             cin,
    output logic [DW-1:0]    res,
    output flags_t           fl
);
    logic          ci;
    logic [DW:0]   wide;
    logic [NIB:0]  low;

    always_comb begin
        ci = (kind == OP_ADC) ? cin : 1'b0;
        if (kind == OP_SUB) begin
            wide = {1'b0, a} - {1'b0, b};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, ci};
        end
        res  = wide[DW-1:0];
        fl.z = (wide[DW-1:0] == '0);
        fl.n = (kind == OP_SUB);
        fl.h = low[NIB];
        fl.c = wide[DW];
    end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
    import acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [DW-1:0]    ld_data,
    input  logic             ex_we,
    input  logic [DW-1:0]    ex_res,
    input  flags_t           ex_flags,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    a_q,
    output logic [DW-1:0]    h_q,
    output logic [DW-1:0]    l_q,
    output flags_t           flags_q
);
    logic [DW-1:0] rbank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == SRC_MEM) begin : g_hole
            assign rbank[i] = '0;
        end else begin : g_ff
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (ex_we && (i == SRC_A))
                    q <= ex_res;
                else if (ld_en && (ld_sel == SEL_W'(i)))
                    q <= ld_data;
            end
            assign rbank[i] = q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (ex_we)
            flags_q <= ex_flags;
        else if (ld_en && (ld_sel == SEL_W'(SRC_MEM)))
            flags_q <= flags_t'(ld_data[DW-1 -: FLAG_W]);
    end

    assign rd_data = rbank[rd_sel];
    assign a_q     = rbank[SRC_A];
    assign h_q     = rbank[SRC_H];
    assign l_q     = rbank[SRC_L];
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_opcode,
    input  logic [DW-1:0]    in_imm,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [DW-1:0]    mem_rd_data,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [DW-1:0]    ld_data,
    output logic [DW-1:0]    acc_out,
    output logic [DW-1:0]    flags_out,
    output logic             done
);
    state_t        st_q;
    dec_t          dec_q;
    logic [DW-1:0] imm_q;
    dec_t          dec_in;
    logic          accept;
    logic [DW-1:0] src_val, opnd_b, alu_res, h_q, l_q;
    flags_t        alu_fl, flags_q;
    op_kind_t      cur_kind;
    logic          ex_we;

    assign dec_in   = decode_op(in_opcode);
    assign in_ready = (st_q == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign cur_kind = dec_q.kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            dec_q <= '0;
            imm_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    dec_q <= dec_in;
                    imm_q <= in_imm;
                    st_q  <= dec_in.use_mem ? ST_MREQ : ST_EXEC;
                end
                ST_MREQ: st_q <= ST_EXEC;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en   = (st_q == ST_MREQ);
    assign mem_rd_addr = {h_q, l_q};
    assign done        = (st_q == ST_EXEC);
    assign ex_we       = done && (dec_q.kind != OP_NONE);

    always_comb begin
        if (dec_q.use_imm)
            opnd_b = imm_q;
        else if (dec_q.use_mem)
            opnd_b = mem_rd_data;
        else
            opnd_b = src_val;
    end

    acc_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_data  (ld_data),
        .ex_we    (ex_we),
        .ex_res   (alu_res),
        .ex_flags (alu_fl),
        .rd_sel   (dec_q.src),
        .rd_data  (src_val),
        .a_q      (acc_out),
        .h_q      (h_q),
        .l_q      (l_q),
        .flags_q  (flags_q)
    );

    acc_alu_core u_alu (
        .kind (dec_q.kind),
        .a    (acc_out),
        .b    (opnd_b),
        .cin  (flags_q.c),
        .res  (alu_res),
        .fl   (alu_fl)
    );

    assign flags_out = {flags_q, {(DW-FLAG_W){1'b0}}};
endmodule

// File: rtl/acc_alu_checks.sv
module acc_alu_checks
    import acc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_ready,
    input logic          done,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic [DW-1:0] h_q,
    input logic [DW-1:0] l_q,
    input logic [DW-1:0] acc_out,
    input logic [DW-1:0] flags_out,
    input op_kind_t      kind,
    input logic          ld_en
);
    assert_ready_excl_R2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!done && !mem_rd_en));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_mem_addr_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_rd_addr == {h_q, l_q}));

    assert_mem_then_done_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> done);

    assert_flag_nibble_R8: assert property (@(posedge clk) disable iff (rst)
        flags_out[3:0] == 4'b0000);

    assert_sub_sets_n_R6: assert property (@(posedge clk) disable iff (rst)
        (done && kind == OP_SUB) |=> flags_out[6]);

    assert_add_clears_n_R4: assert property (@(posedge clk) disable iff (rst)
        (done && (kind == OP_ADD || kind == OP_ADC)) |=> !flags_out[6]);

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (done && kind != OP_NONE) |=> (flags_out[7] == (acc_out == '0)));

    assert_bad_op_R10: assert property (@(posedge clk) disable iff (rst)
        (done && kind == OP_NONE && !ld_en) |=> ($stable(acc_out) && $stable(flags_out)));
endmodule

bind acc_alu_unit acc_alu_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .done        (done),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .h_q         (h_q),
    .l_q         (l_q),
    .acc_out     (acc_out),
    .flags_out   (flags_out),
    .kind        (cur_kind),
    .ld_en       (ld_en)
);

// File: tb/tb_acc_alu_unit.sv
module tb_acc_alu_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 23;
    // fields: opcode, imm, A before, source value, flags before, memory byte, A after, flags after
    localparam logic [63:0] VECS [NVEC] = '{
        {8'h80, 8'h00, 8'h0A, 8'h14, 8'hF0, 8'h00, 8'h1E, 8'h00},
        {8'h81, 8'h00, 8'h0F, 8'h01, 8'h00, 8'h00, 8'h10, 8'h20},
        {8'h81, 8'h00, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00, 8'h90},
        {8'h82, 8'h00, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 8'hB0},
        {8'h87, 8'h00, 8'h0A, 8'h00, 8'h10, 8'h00, 8'h14, 8'h20},
        {8'h86, 8'h00, 8'h12, 8'h00, 8'hF0, 8'h34, 8'h46, 8'h00},
        {8'hC6, 8'h13, 8'h32, 8'h00, 8'h00, 8'h00, 8'h45, 8'h00},
        {8'h88, 8'h00, 8'h12, 8'h05, 8'h10, 8'h00, 8'h18, 8'h00},
        {8'h89, 8'h00, 8'h00, 8'h00, 8'h10, 8'h00, 8'h01, 8'h00},
        {8'h8F, 8'h00, 8'h0E, 8'h00, 8'h10, 8'h00, 8'h1D, 8'h20},
        {8'h8F, 8'h00, 8'hF0, 8'h00, 8'h10, 8'h00, 8'hE1, 8'h10},
        {8'hCE, 8'h00, 8'hFF, 8'h00, 8'h10, 8'h00, 8'h00, 8'hB0},
        {8'h8E, 8'h00, 8'h0E, 8'h00, 8'h10, 8'hF0, 8'hFF, 8'h00},
        {8'h90, 8'h00, 8'hFF, 8'h0F, 8'hB0, 8'h00, 8'hF0, 8'h40},
        {8'h92, 8'h00, 8'hF0, 8'h0F, 8'h00, 8'h00, 8'hE1, 8'h60},
        {8'h95, 8'h00, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h1F, 8'h50},
        {8'h97, 8'h00, 8'hFF, 8'h00, 8'h30, 8'h00, 8'h00, 8'hC0},
        {8'h96, 8'h00, 8'h01, 8'h00, 8'h10, 8'h01, 8'h00, 8'hC0},
        {8'h8D, 8'h00, 8'h0F, 8'h0F, 8'h00, 8'h00, 8'h1E, 8'h20},
        {8'h84, 8'h00, 8'h10, 8'h20, 8'h00, 8'h00, 8'h30, 8'h00},
        {8'h83, 8'h00, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h80},
        {8'hCE, 8'h80, 8'h0F, 8'h00, 8'h10, 8'h00, 8'h90, 8'h20},
        {8'h8B, 8'h00, 8'hFF, 8'hFF, 8'h10, 8'h00, 8'hFF, 8'h30}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_opcode, in_imm;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        ld_en;
    logic [2:0]  ld_sel;
    logic [7:0]  ld_data;
    logic [7:0]  acc_out, flags_out;
    logic        done;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_unit dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_opcode (in_opcode), .in_imm (in_imm), .mem_rd_en (mem_rd_en),
        .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data), .ld_en (ld_en),
        .ld_sel (ld_sel), .ld_data (ld_data), .acc_out (acc_out),
        .flags_out (flags_out), .done (done)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    task automatic load(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // returns cycles from acceptance to done, memory activity, and whether ready rose while busy
    task automatic run_op(input logic [7:0] opc, input logic [7:0] imm,
                          output int lat, output logic saw_mem, output logic [15:0] maddr,
                          output logic busy_ready);
        @(negedge clk);
        in_valid = 1'b1; in_opcode = opc; in_imm = imm;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1; saw_mem = 1'b0; maddr = '0; busy_ready = 1'b0;
        while (!done && lat < 10) begin
            if (mem_rd_en) begin saw_mem = 1'b1; maddr = mem_rd_addr; end
            if (in_ready) busy_ready = 1'b1;
            @(negedge clk);
            lat++;
        end
        if (in_ready) busy_ready = 1'b1;
        @(negedge clk);
    endtask

    function automatic string kind_tag(input logic [7:0] opc);
        if (opc[7:3] == 5'b10000 || opc == 8'hC6) return "R4";
        if (opc[7:3] == 5'b10001 || opc == 8'hCE) return "R5";
        return "R6";
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int lat;
        logic sm, br;
        logic [15:0] ma;
        rst = 1'b1; in_valid = 1'b0; in_opcode = '0; in_imm = '0;
        mem_rd_data = '0; ld_en = 1'b0; ld_sel = '0; ld_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "acc", {8'h0, acc_out}, 16'h0);
        chk("R1", "flags", {8'h0, flags_out}, 16'h0);
        chk("R1", "ready", {15'h0, in_ready}, 16'h1);
        chk("R1", "done", {15'h0, done}, 16'h0);
        chk("R1", "mem_rd_en", {15'h0, mem_rd_en}, 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] opc, imm, a0, sv, pf, mv, ea, ef;
            logic is_mem, is_imm;
            string t;
            {opc, imm, a0, sv, pf, mv, ea, ef} = VECS[i];
            is_imm = (opc == 8'hC6) || (opc == 8'hCE);
            is_mem = !is_imm && (opc[2:0] == 3'd6);
            t = kind_tag(opc);
            load(3'd7, a0);
            // R3: source register chosen by opcode[2:0]
            if (!is_imm && opc[2:0] != 3'd6 && opc[2:0] != 3'd7) load(opc[2:0], sv);
            if (is_mem) begin load(3'd4, 8'hC1); load(3'd5, 8'h2F); end
            load(3'd6, pf);
            mem_rd_data = mv;
            run_op(opc, imm, lat, sm, ma, br);
            chk(t, $sformatf("vec %0d result", i), {8'h0, acc_out}, {8'h0, ea});
            chk({t, "+R7"}, $sformatf("vec %0d flags", i), {8'h0, flags_out}, {8'h0, ef});
            chk("R2", $sformatf("vec %0d ready while busy", i), {15'h0, br}, 16'h0);
            if (is_mem) begin
                chk("R9", $sformatf("vec %0d latency", i), 16'(lat), 16'd2);
                chk("R9", $sformatf("vec %0d address", i), ma, 16'hC12F);
            end else begin
                chk("R2", $sformatf("vec %0d latency", i), 16'(lat), 16'd1);
                chk("R9", $sformatf("vec %0d no read", i), {15'h0, sm}, 16'h0);
            end
        end

        // R10: unsupported opcodes change nothing
        load(3'd7, 8'h5A);
        load(3'd6, 8'hA0);
        foreach (VECS[k]) begin end
        run_op(8'h00, 8'h00, lat, sm, ma, br);
        chk("R10", "lat 0x00", 16'(lat), 16'd1);
        chk("R10", "acc 0x00", {8'h0, acc_out}, 16'h005A);
        chk("R10", "flags 0x00", {8'h0, flags_out}, 16'h00A0);
        run_op(8'hA7, 8'h00, lat, sm, ma, br);
        chk("R10", "acc 0xA7", {8'h0, acc_out}, 16'h005A);
        chk("R10", "flags 0xA7", {8'h0, flags_out}, 16'h00A0);
        run_op(8'hC7, 8'h11, lat, sm, ma, br);
        chk("R10", "acc 0xC7", {8'h0, acc_out}, 16'h005A);
        chk("R10", "flags 0xC7", {8'h0, flags_out}, 16'h00A0);

        // R8 / R11: flag load keeps only the upper nibble
        load(3'd6, 8'hFF);
        chk("R8", "flag nibble", {8'h0, flags_out}, 16'h00F0);
        load(3'd7, 8'h3C);
        chk("R11", "load A", {8'h0, acc_out}, 16'h003C);

        // R1: reset after activity clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", "acc after reset", {8'h0, acc_out}, 16'h0);
        chk("R1", "flags after reset", {8'h0, flags_out}, 16'h0);
        // R1: B was cleared too: ADD B gives A+0
        load(3'd7, 8'h21);
        run_op(8'h80, 8'h00, lat, sm, ma, br);
        chk("R1", "B cleared", {8'h0, acc_out}, 16'h0021);

        summary();
        $finish;
    end
endmodule